// File: doc/BRIEF.md
# Interrupt Enable Set/Clear Controller

This block sits between a set of peripheral request lines and a processor core. It has one enable bit and one pending bit for each line, with lines grouped into 32-bit words. Software never rewrites an enable word whole. Each word has a set alias, where every bit written as one turns an enable on, and a clear alias, where every bit written as one turns an enable off. Bits written as zero change nothing. Because of this, separate software agents can each switch their own lines without a read-modify-write, and none of them can undo another agent's change.

A rising edge on a request input latches that line's pending flag, even when the line is disabled, so software can poll for events. Pending flags have their own set and clear aliases with the same write-one behaviour. The core interrupt is raised only for a line that is both pending and enabled. The block also reports the lowest-numbered such line.

Top module: `irq_enable_ctrl`

## Requirements
- R1: After reset, every enable bit and every pending bit reads zero, and `core_irq_o` and `active_valid_o` are low.
- R2: A write to alias code 0 (enable-set) turns on the enable bits written as one and leaves the bits written as zero as they were. Enabling line 8 and then line 7 in separate writes leaves both enabled.
- R3: A write to alias code 1 (enable-clear) turns off the enable bits written as one and leaves the others as they were. Writing all ones clears the whole word.
- R4: `bus_addr_i` is {alias code in the top two bits, word index in the low WIDX_W bits}. Line n is bit n&31 of word n>>5. Reading alias 0 or 1 returns that word's enable bits. Reading alias 2 or 3 returns its pending bits.
- R5: A rising edge on `irq_req_i[n]` sets pending bit n at the clock edge where the input is first seen high, whether or not line n is enabled.
- R6: A write to alias code 2 (pending-set) sets the pending bits written as one. A write to alias code 3 (pending-clear) clears them at that write's clock edge. When a request edge and a pending-clear of the same line fall in the same cycle, the line stays pending.
- R7: If a request input is still high when its pending bit is cleared, the bit reads zero for one cycle and is set again at the next edge. A low request is not re-latched.
- R8: `core_irq_o` is high exactly when at least one line is both pending and enabled.
- R9: `active_valid_o` follows `core_irq_o`, and `active_id_o` gives the lowest-numbered line that is pending and enabled. `active_id_o` is zero when no line is.
- R10: Writes to word indices at or above ceil(NUM_LINES/32) change no state, and reads of those indices return zero. Bits above the last line in the top word read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_wr_i | input | 1 | Write strobe, one cycle per write |
| bus_addr_i | input | WIDX_W+2 | Alias code and word index |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for the addressed word (combinational) |
| irq_req_i | input | NUM_LINES | Peripheral request lines |
| core_irq_o | output | 1 | Interrupt request to the core |
| active_valid_o | output | 1 | A line is pending and enabled |
| active_id_o | output | clog2(NUM_LINES) | Lowest pending and enabled line |

## Verification
Two functions can act on the same pending bit in one cycle: the edge detector, which sets it, and a software pending-clear, which clears it. The bench raises a request at the same falling edge where it starts a pending-clear of that line, and expects the bit to read set afterwards. A second sequence holds a request high through a clear. The bench expects the bit to read zero on the first poll and set on the poll one cycle later. A control case with the request low expects no re-latch.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

  localparam int WORD_W = 32;

  typedef enum logic [1:0] {
    ALIAS_EN_SET = 2'd0,
    ALIAS_EN_CLR = 2'd1,
    ALIAS_PD_SET = 2'd2,
    ALIAS_PD_CLR = 2'd3
  } alias_e;

  // number of implemented lines that land in word w
  function automatic int lanes_in_word(input int lines, input int w);
    int rem;
    rem = lines - w * WORD_W;
    if (rem >= WORD_W) return WORD_W;
    if (rem > 0) return rem;
    return 0;
  endfunction

endpackage

// File: rtl/irqc_rst_sync.sv
module irqc_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);

  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b00;
    else         sync_q <= sync_d;
  end

  assign rst_no = sync_q[1];

endmodule

// File: rtl/irqc_bus_decode.sv
module irqc_bus_decode #(
  parameter int NUM_WORDS = 2,
  parameter int WIDX_W    = 2,
  localparam int ADDR_W   = WIDX_W + 2
) (
  input  logic                 bus_wr_i,
  input  logic [ADDR_W-1:0]    bus_addr_i,
  output logic [NUM_WORDS-1:0] en_set_stb_o,
  output logic [NUM_WORDS-1:0] en_clr_stb_o,
  output logic [NUM_WORDS-1:0] pd_set_stb_o,
  output logic [NUM_WORDS-1:0] pd_clr_stb_o,
  output logic                 rd_pend_o,
  output logic [WIDX_W-1:0]    rd_idx_o
);
  import irqc_pkg::*;

  alias_e            kind;
  logic [WIDX_W-1:0] idx;

  assign kind = alias_e'(bus_addr_i[ADDR_W-1 -: 2]);
  assign idx  = bus_addr_i[WIDX_W-1:0];

  // a write strobe exists only for implemented words; others fall away
  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word_stb
    logic hit;
    assign hit             = bus_wr_i && (int'(idx) == w);
    assign en_set_stb_o[w] = hit && (kind == ALIAS_EN_SET);
    assign en_clr_stb_o[w] = hit && (kind == ALIAS_EN_CLR);
    assign pd_set_stb_o[w] = hit && (kind == ALIAS_PD_SET);
    assign pd_clr_stb_o[w] = hit && (kind == ALIAS_PD_CLR);
  end

  assign rd_pend_o = (kind == ALIAS_PD_SET) || (kind == ALIAS_PD_CLR);
  assign rd_idx_o  = idx;

endmodule

// File: rtl/irqc_word.sv
module irqc_word #(
  parameter int LANES = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_set_i,
  input  logic             en_clr_i,
  input  logic             pd_set_i,
  input  logic             pd_clr_i,
  input  logic [LANES-1:0] wdata_i,
  input  logic [LANES-1:0] req_i,
  output logic [LANES-1:0] en_o,
  output logic [LANES-1:0] pend_o
);

  logic [LANES-1:0] en_q, en_d;
  logic             en_we;
  logic [LANES-1:0] pend_q, pend_d;
  logic [LANES-1:0] req_q;
  logic [LANES-1:0] relatch_q, relatch_d;
  logic [LANES-1:0] rise, set_m, clr_m;

  always_comb begin
    en_we = en_set_i || en_clr_i;
    en_d  = en_q;
    if (en_set_i) en_d = en_q | wdata_i;
    if (en_clr_i) en_d = en_q & ~wdata_i;
  end

  // every set source outranks a clear landing in the same cycle
  always_comb begin
    rise      = req_i & ~req_q;
    set_m     = rise | (pd_set_i ? wdata_i : '0) | (relatch_q & req_i);
    clr_m     = pd_clr_i ? wdata_i : '0;
    pend_d    = (pend_q & ~clr_m) | set_m;
    relatch_d = clr_m & req_i & ~set_m;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q <= '0;
    end else if (en_we) begin
      en_q <= en_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q    <= '0;
      req_q     <= '0;
      relatch_q <= '0;
    end else begin
      pend_q    <= pend_d;
      req_q     <= req_i;
      relatch_q <= relatch_d;
    end
  end

  assign en_o   = en_q;
  assign pend_o = pend_q;

endmodule

// File: rtl/irqc_lowest_sel.sv
module irqc_lowest_sel #(
  parameter int N    = 48,
  parameter int ID_W = 6
) (
  input  logic [N-1:0]    hit_i,
  output logic            valid_o,
  output logic [ID_W-1:0] id_o
);

  // scan from the top so that the lowest set index is written last
  always_comb begin
    valid_o = 1'b0;
    id_o    = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (hit_i[i]) begin
        valid_o = 1'b1;
        id_o    = ID_W'(i);
      end
    end
  end

endmodule

// File: rtl/irq_enable_ctrl.sv
module irq_enable_ctrl #(
  parameter int NUM_LINES = 48,
  parameter int WIDX_W    = 2,
  localparam int NUM_WORDS = (NUM_LINES + 31) / 32,
  localparam int ADDR_W    = WIDX_W + 2,
  localparam int ID_W      = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 bus_wr_i,
  input  logic [ADDR_W-1:0]    bus_addr_i,
  input  logic [31:0]          bus_wdata_i,
  output logic [31:0]          bus_rdata_o,
  input  logic [NUM_LINES-1:0] irq_req_i,
  output logic                 core_irq_o,
  output logic                 active_valid_o,
  output logic [ID_W-1:0]      active_id_o
);
  import irqc_pkg::*;

  localparam int PAD_W = NUM_WORDS * WORD_W;

  logic                 rst_n;
  logic [NUM_WORDS-1:0] en_set_stb, en_clr_stb, pd_set_stb, pd_clr_stb;
  logic                 rd_pend;
  logic [WIDX_W-1:0]    rd_idx;
  logic [NUM_LINES-1:0] en_flat, pend_flat, hit;
  logic [PAD_W-1:0]     en_pad, pend_pad;

  irqc_rst_sync u_rst (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_n)
  );

  irqc_bus_decode #(
    .NUM_WORDS (NUM_WORDS),
    .WIDX_W    (WIDX_W)
  ) u_dec (
    .bus_wr_i     (bus_wr_i),
    .bus_addr_i   (bus_addr_i),
    .en_set_stb_o (en_set_stb),
    .en_clr_stb_o (en_clr_stb),
    .pd_set_stb_o (pd_set_stb),
    .pd_clr_stb_o (pd_clr_stb),
    .rd_pend_o    (rd_pend),
    .rd_idx_o     (rd_idx)
  );

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    localparam int LO    = w * WORD_W;
    localparam int LANES = lanes_in_word(NUM_LINES, w);
    irqc_word #(
      .LANES (LANES)
    ) u_word (
      .clk_i    (clk_i),
      .rst_ni   (rst_n),
      .en_set_i (en_set_stb[w]),
      .en_clr_i (en_clr_stb[w]),
      .pd_set_i (pd_set_stb[w]),
      .pd_clr_i (pd_clr_stb[w]),
      .wdata_i  (bus_wdata_i[LANES-1:0]),
      .req_i    (irq_req_i[LO +: LANES]),
      .en_o     (en_flat[LO +: LANES]),
      .pend_o   (pend_flat[LO +: LANES])
    );
  end

  assign en_pad   = PAD_W'(en_flat);
  assign pend_pad = PAD_W'(pend_flat);

  always_comb begin
    bus_rdata_o = '0;
    for (int w = 0; w < NUM_WORDS; w++) begin
      if (int'(rd_idx) == w) begin
        bus_rdata_o = rd_pend ? pend_pad[w*WORD_W +: WORD_W]
                              : en_pad[w*WORD_W +: WORD_W];
      end
    end
  end

  assign hit        = en_flat & pend_flat;
  assign core_irq_o = |hit;

  irqc_lowest_sel #(
    .N    (NUM_LINES),
    .ID_W (ID_W)
  ) u_sel (
    .hit_i   (hit),
    .valid_o (active_valid_o),
    .id_o    (active_id_o)
  );

endmodule

// File: rtl/irqc_chk.sv
module irqc_chk #(
  parameter int NUM_LINES = 48,
  parameter int WIDX_W    = 2,
  localparam int NUM_WORDS = (NUM_LINES + 31) / 32,
  localparam int ADDR_W    = WIDX_W + 2,
  localparam int ID_W      = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1,
  localparam int PAD_W     = NUM_WORDS * 32
) (
  input logic                 clk_i,
  input logic                 rst_n,
  input logic                 bus_wr_i,
  input logic [ADDR_W-1:0]    bus_addr_i,
  input logic [31:0]          bus_wdata_i,
  input logic [31:0]          bus_rdata_o,
  input logic [NUM_LINES-1:0] irq_req_i,
  input logic [NUM_LINES-1:0] en_flat,
  input logic [NUM_LINES-1:0] pend_flat,
  input logic                 core_irq_o,
  input logic                 active_valid_o,
  input logic [ID_W-1:0]      active_id_o
);

  localparam logic [PAD_W-1:0] IMPL = PAD_W'({NUM_LINES{1'b1}});

  function automatic logic [31:0] pick(input logic [PAD_W-1:0] v, input int i);
    if (i < NUM_WORDS) return v[i*32 +: 32];
    return '0;
  endfunction

  logic [1:0]           kind;
  int                   idx;
  logic                 idx_ok;
  logic [PAD_W-1:0]     en_pad;
  logic [NUM_LINES-1:0] req_d, rise;

  assign kind   = bus_addr_i[ADDR_W-1 -: 2];
  assign idx    = int'(bus_addr_i[WIDX_W-1:0]);
  assign idx_ok = idx < NUM_WORDS;
  assign en_pad = PAD_W'(en_flat);
  assign rise   = irq_req_i & ~req_d;

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) req_d <= '0;
    else        req_d <= irq_req_i;
  end

  // R1
  reset_state_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    !$past(rst_n) |-> (en_flat == '0 && pend_flat == '0 && !core_irq_o));

  // R2
  en_set_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (bus_wr_i && kind == 2'd0 && idx_ok) |=>
      ((pick(en_pad, $past(idx)) & $past(bus_wdata_i)) ==
       ($past(bus_wdata_i) & pick(IMPL, $past(idx)))));

  // R3
  en_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (bus_wr_i && kind == 2'd1 && idx_ok) |=>
      ((pick(en_pad, $past(idx)) & $past(bus_wdata_i)) == 32'd0));

  // R5
  pend_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (|rise) |=> ((pend_flat & $past(rise)) == $past(rise)));

  // R9
  active_match_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    active_valid_o == core_irq_o);

  // R9
  active_lowest_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    active_valid_o |-> (en_flat[active_id_o] && pend_flat[active_id_o] &&
      ((en_flat & pend_flat & ~({NUM_LINES{1'b1}} << active_id_o)) == '0)));

  // R10
  oor_write_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (bus_wr_i && !idx_ok) |=> $stable(en_flat));

  // R10
  oor_read_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    !idx_ok |-> bus_rdata_o == 32'd0);

endmodule

bind irq_enable_ctrl irqc_chk #(
  .NUM_LINES (NUM_LINES),
  .WIDX_W    (WIDX_W)
) u_chk (
  .clk_i          (clk_i),
  .rst_n          (rst_n),
  .bus_wr_i       (bus_wr_i),
  .bus_addr_i     (bus_addr_i),
  .bus_wdata_i    (bus_wdata_i),
  .bus_rdata_o    (bus_rdata_o),
  .irq_req_i      (irq_req_i),
  .en_flat        (en_flat),
  .pend_flat      (pend_flat),
  .core_irq_o     (core_irq_o),
  .active_valid_o (active_valid_o),
  .active_id_o    (active_id_o)
);

// File: tb/tb_irq_enable_ctrl.sv
module tb_irq_enable_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int NUM_LINES  = 48;
  localparam int WIDX_W     = 2;
  localparam int ADDR_W     = WIDX_W + 2;
  localparam int ID_W       = $clog2(NUM_LINES);
  localparam logic [1:0] ESET = 2'd0, ECLR = 2'd1, PSET = 2'd2, PCLR = 2'd3;

  logic                 clk = 1'b0;
  logic                 rst_ni = 1'b0;
  logic                 bus_wr = 1'b0;
  logic [ADDR_W-1:0]    bus_addr = '0;
  logic [31:0]          bus_wdata = '0;
  logic [31:0]          bus_rdata;
  logic [NUM_LINES-1:0] req = '0;
  logic                 core_irq, act_valid;
  logic [ID_W-1:0]      act_id;

  typedef struct {
    bit          is_irq;
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t q[$];
  int    n_cmp = 0;
  int    n_bad = 0;
  bit    done  = 1'b0;

  irq_enable_ctrl #(.NUM_LINES(NUM_LINES), .WIDX_W(WIDX_W)) dut (
    .clk_i          (clk),
    .rst_ni         (rst_ni),
    .bus_wr_i       (bus_wr),
    .bus_addr_i     (bus_addr),
    .bus_wdata_i    (bus_wdata),
    .bus_rdata_o    (bus_rdata),
    .irq_req_i      (req),
    .core_irq_o     (core_irq),
    .active_valid_o (act_valid),
    .active_id_o    (act_id)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [ADDR_W-1:0] mk(input logic [1:0] k, input int idx);
    return {k, WIDX_W'(idx)};
  endfunction

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] k, input int idx, input logic [31:0] d);
    bus_wr    = 1'b1;
    bus_addr  = mk(k, idx);
    bus_wdata = d;
    @(negedge clk);
    bus_wr    = 1'b0;
    bus_wdata = '0;
  endtask

  task automatic chk_rd(input logic [1:0] k, input int idx, input logic [31:0] e,
                        input string tag);
    item_t it;
    bus_addr = mk(k, idx);
    it.is_irq = 1'b0; it.exp = e; it.tag = tag;
    q.push_back(it);
    @(negedge clk);
  endtask

  task automatic chk_irq(input bit v, input int id, input string tag);
    item_t it;
    it.is_irq = 1'b1;
    it.exp    = 32'({v, v, ID_W'(id)});
    it.tag    = tag;
    q.push_back(it);
    @(negedge clk);
  endtask

  // monitor: compare queued expectations a quarter period after the falling edge
  initial begin
    forever begin
      @(negedge clk);
      #(CLK_PERIOD/4);
      while (q.size() > 0) begin
        item_t it;
        logic [31:0] act;
        it  = q.pop_front();
        act = it.is_irq ? 32'({core_irq, act_valid, act_id}) : bus_rdata;
        n_cmp++;
        if (act !== it.exp) begin
          n_bad++;
          $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    chk_rd(ESET, 0, 32'h0, "R1 enable w0");
    chk_rd(ECLR, 1, 32'h0, "R1 enable w1");
    chk_rd(PSET, 0, 32'h0, "R1 pending w0");
    chk_irq(1'b0, 0, "R1 irq idle");

    // R2 separate set writes accumulate
    wr(ESET, 0, 32'h100);
    wr(ESET, 0, 32'h080);
    chk_rd(ECLR, 0, 32'h180, "R2 line8 then line7");

    // R4 line 40 maps to word 1 bit 8; R10 unimplemented lanes
    wr(ESET, 1, 32'h100);
    chk_rd(ESET, 1, 32'h100, "R4 line40 mapping");
    wr(ESET, 1, 32'hFFFF_FFFF);
    chk_rd(ESET, 1, 32'h0000_FFFF, "R10 upper lanes zero");

    // R3 clear alias
    wr(ECLR, 1, 32'h100);
    chk_rd(ESET, 1, 32'h0000_FEFF, "R3 single clear");
    wr(ECLR, 1, 32'hFFFF_FFFF);
    chk_rd(ECLR, 1, 32'h0, "R3 all ones clear");
    wr(ECLR, 0, 32'h080);
    chk_rd(ESET, 0, 32'h100, "R3 clear keeps others");
    chk_irq(1'b0, 0, "R8 nothing pending");

    // R5 disabled line still latches pending
    req[5] = 1'b1;
    tick();
    chk_rd(PSET, 0, 32'h20, "R5 edge latch disabled");
    chk_irq(1'b0, 0, "R8 pending but disabled");
    wr(ESET, 0, 32'h20);
    chk_irq(1'b1, 5, "R8 pending and enabled");

    // R6 pending set alias, R9 lowest wins
    wr(ESET, 0, 32'h200);
    wr(PSET, 0, 32'h200);
    chk_rd(PCLR, 0, 32'h220, "R6 pending set");
    chk_irq(1'b1, 5, "R9 lowest of 5,9");
    req[5] = 1'b0;
    tick();
    wr(PCLR, 0, 32'h20);
    chk_rd(PSET, 0, 32'h200, "R6 pending clear");
    chk_irq(1'b1, 9, "R9 next lowest");

    // R9 across words
    wr(ESET, 1, 32'h2);
    wr(PSET, 1, 32'h2);
    chk_irq(1'b1, 9, "R9 9 below 33");
    wr(ECLR, 0, 32'h200);
    chk_irq(1'b1, 33, "R9 word1 line");
    wr(PSET, 0, 32'h100);
    chk_irq(1'b1, 8, "R9 line8 below 33");

    // R6 request edge and pending-clear in the same cycle
    req[12] = 1'b1;
    wr(PCLR, 0, 32'h1000);
    chk_rd(PSET, 0, 32'h1300, "R6 edge beats clear");
    req[12] = 1'b0;
    tick();

    // R7 held request re-latches after clear
    req[3] = 1'b1;
    tick();
    chk_rd(PSET, 0, 32'h1308, "R5 line3 latched");
    wr(PCLR, 0, 32'h8);
    chk_rd(PSET, 0, 32'h1300, "R7 cleared cycle");
    chk_rd(PSET, 0, 32'h1308, "R7 relatched");
    req[3] = 1'b0;
    wr(PCLR, 0, 32'h8);
    chk_rd(PSET, 0, 32'h1300, "R7 low cleared");
    chk_rd(PSET, 0, 32'h1300, "R7 low no relatch");

    // R10 out-of-range indices
    wr(ESET, 2, 32'hFFFF_FFFF);
    wr(PCLR, 3, 32'hFFFF_FFFF);
    wr(ECLR, 3, 32'hFFFF_FFFF);
    chk_rd(ESET, 2, 32'h0, "R10 read idx2");
    chk_rd(PSET, 3, 32'h0, "R10 read idx3");
    chk_rd(ESET, 0, 32'h120, "R10 enables untouched");
    chk_rd(PSET, 0, 32'h1300, "R10 pending untouched");
    chk_rd(ESET, 1, 32'h2, "R10 word1 untouched");

    // R3 full word clear, R8 drop
    wr(ECLR, 0, 32'hFFFF_FFFF);
    chk_rd(ESET, 0, 32'h0, "R3 w0 all cleared");
    chk_irq(1'b1, 33, "R9 only 33 left");
    wr(ECLR, 1, 32'hFFFF_FFFF);
    chk_irq(1'b0, 0, "R8 all disabled");

    tick();
    tick();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule